// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular ring of transmit descriptors held in a small on-chip dual-port RAM. Each descriptor names a byte buffer in the same RAM and carries ownership and framing flags. The engine fetches a descriptor that software has marked ready, streams the referenced bytes one per cycle onto a byte-wide frame interface with start and end markers, and then writes the descriptor back with its ready flag cleared so that software owns it again. Software fills descriptors and buffers through a plain word-wide access port on the other side of the RAM.

The engine comes out of reset halted. It also halts when it fetches a descriptor that software has not marked ready. It then waits for a one-cycle halt-clear strobe and fetches that same descriptor again. A graceful-stop request lets the frame in progress finish and then parks the engine with an acknowledge held high until the request is withdrawn. Line coding and frame check generation belong to the downstream MAC. The engine only passes along, with the end marker, the descriptor's request to append a frame check sequence.

Top module: `txring_engine`

## Requirements
- R1: After synchronous reset, `tx_halted` is 1, `fr_valid`, `tx_irq` and `gstop_ack` are 0, and the first fetch after a halt-clear comes from `ring_base`.
- R2: A descriptor sits at an 8-byte aligned byte address. Its first word holds status in bits 31:16 and the byte length (at least 1) in bits 15:0. Its second word holds the buffer's byte address. A byte at byte address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of RAM word a/4.
- R3: The status flags are READY (bit 15), WRAP (bit 13), INTR (bit 12), LAST (bit 11) and CRC (bit 10).
- R4: A ready descriptor produces exactly `length` bytes on `fr_data` with `fr_valid` high, taken in ascending address order from the buffer pointer, for any byte alignment of that pointer.
- R5: After the last byte of a descriptor, its first word is rewritten with READY cleared and every other status bit and the length unchanged. This happens no earlier than the cycle in which that byte appears.
- R6: After a descriptor with WRAP set, the next fetch comes from `ring_base`. Otherwise it comes from the descriptor address plus 8.
- R7: Fetching a descriptor with READY clear sets `tx_halted`, emits nothing and leaves the descriptor unchanged. The engine stays halted until a `halt_clr` pulse, and then it fetches the same descriptor again.
- R8: `fr_sof` marks the first byte after reset or after an end marker. `fr_eof` marks only the final byte of a descriptor with LAST set. Bytes from several descriptors without LAST form one frame.
- R9: `fr_crc` is high only together with `fr_eof`, and only when the ending descriptor has CRC set.
- R10: `tx_irq` pulses for exactly one cycle for each returned descriptor that has INTR set.
- R11: While `gstop_req` is high, the engine completes any open frame, then raises `gstop_ack` and fetches nothing. Dropping the request lowers the acknowledge and resumes at the next descriptor.
- R12: `sw_rdata` shows the RAM word at `sw_addr` one clock later. A software write and an engine write to the same word in the same cycle resolve in favour of the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | MEM_AW | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, one cycle latency |
| ring_base | input | MEM_AW+2 | Byte address of the first descriptor |
| halt_clr | input | 1 | One-cycle strobe releasing the halted state |
| gstop_req | input | 1 | Graceful stop request (level) |
| gstop_ack | output | 1 | Engine parked by a graceful stop |
| tx_halted | output | 1 | Engine halted |
| tx_irq | output | 1 | Completion pulse for descriptors with INTR |
| fr_valid | output | 1 | Frame byte valid |
| fr_data | output | 8 | Frame byte |
| fr_sof | output | 1 | First byte of a frame |
| fr_eof | output | 1 | Last byte of a frame |
| fr_crc | output | 1 | Append frame check sequence (with end marker) |

## Verification
Single-descriptor frames are swept over every length from 1 to 9 and every byte offset 0 to 3. This tells apart lane selection and end-of-buffer counting errors. The two-slot ring alternates, so a wrong wrap step leaves a slot unreached. A three-descriptor frame across misaligned buffers separates per-descriptor marker bugs from per-frame ones. A ready descriptor written while the engine is halted, and another written while it is gracefully stopped, shows whether the engine stays quiet until it is explicitly released. The graceful-stop request is raised in the middle of a two-descriptor frame, which checks that the stop waits for the end marker rather than for the end of a descriptor.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  localparam int ST_READY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_INTR  = 12;
  localparam int ST_LAST  = 11;
  localparam int ST_CRC   = 10;

  localparam logic [HALF_W-1:0] RDY_MASK = HALF_W'(1) << ST_READY;

  typedef enum logic [2:0] {
    S_HALT,
    S_CHECK,
    S_RDLEN,
    S_RDPTR,
    S_STREAM,
    S_RETURN,
    S_STOP
  } eng_state_t;
endpackage

// File: rtl/txr_dpram.sv
module txr_dpram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Port B (engine) is written last so it wins a same-word collision.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW+1:0]       ring_base,
  input  logic                halt_clr,
  input  logic                gstop_req,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_we,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                iss_valid,
  output logic [LANE_W-1:0]   iss_lane,
  output logic                iss_sof,
  output logic                iss_eof,
  output logic                iss_crc,
  output logic                tx_halted,
  output logic                gstop_ack,
  output logic                tx_irq
);
  localparam int BW = AW + 2;
  localparam logic [BW-1:0]     STEP_HALF = BW'(4);
  localparam logic [BW-1:0]     STEP_DESC = BW'(8);
  localparam logic [HALF_W-1:0] ONE_LEFT  = HALF_W'(1);

  eng_state_t        state, nxt;
  logic [BW-1:0]     cur_desc, desc_q, desc_now, desc_p4, ptr_q;
  logic              use_base, frame_open;
  logic [HALF_W-1:0] stat_q, len_q, rem_q;
  logic              last_byte;

  assign desc_now  = use_base ? ring_base : cur_desc;
  assign desc_p4   = desc_q + STEP_HALF;
  assign last_byte = (rem_q == ONE_LEFT);
  assign mem_wdata = {stat_q & ~RDY_MASK, len_q};

  always_comb begin
    nxt       = state;
    mem_addr  = desc_q[BW-1:2];
    mem_we    = 1'b0;
    iss_valid = 1'b0;
    iss_lane  = '0;
    iss_sof   = 1'b0;
    iss_eof   = 1'b0;
    iss_crc   = 1'b0;
    case (state)
      S_HALT: begin
        if (halt_clr) nxt = S_CHECK;
      end
      S_CHECK: begin
        mem_addr = desc_now[BW-1:2];
        if (gstop_req && !frame_open) nxt = S_STOP;
        else                          nxt = S_RDLEN;
      end
      S_RDLEN: begin
        mem_addr = desc_p4[BW-1:2];
        nxt = mem_rdata[HALF_W + ST_READY] ? S_RDPTR : S_HALT;
      end
      S_RDPTR: begin
        nxt = (len_q == '0) ? S_RETURN : S_STREAM;
      end
      S_STREAM: begin
        mem_addr  = ptr_q[BW-1:2];
        iss_valid = 1'b1;
        iss_lane  = ptr_q[LANE_W-1:0];
        iss_sof   = !frame_open;
        iss_eof   = last_byte && stat_q[ST_LAST];
        iss_crc   = last_byte && stat_q[ST_LAST] && stat_q[ST_CRC];
        if (last_byte) nxt = S_RETURN;
      end
      S_RETURN: begin
        mem_we = 1'b1;
        nxt    = S_CHECK;
      end
      S_STOP: begin
        if (!gstop_req) nxt = S_CHECK;
      end
      default: nxt = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_HALT;
      use_base   <= 1'b1;
      cur_desc   <= '0;
      desc_q     <= '0;
      stat_q     <= '0;
      len_q      <= '0;
      rem_q      <= '0;
      ptr_q      <= '0;
      frame_open <= 1'b0;
      tx_halted  <= 1'b1;
      gstop_ack  <= 1'b0;
      tx_irq     <= 1'b0;
    end else begin
      state     <= nxt;
      tx_halted <= (nxt == S_HALT);
      gstop_ack <= (nxt == S_STOP);
      tx_irq    <= (state == S_RETURN) && stat_q[ST_INTR];
      case (state)
        S_CHECK: desc_q <= desc_now;
        S_RDLEN: begin
          stat_q <= mem_rdata[WORD_W-1:HALF_W];
          len_q  <= mem_rdata[HALF_W-1:0];
        end
        S_RDPTR: begin
          ptr_q <= mem_rdata[BW-1:0];
          rem_q <= len_q;
        end
        S_STREAM: begin
          ptr_q <= ptr_q + BW'(1);
          rem_q <= rem_q - ONE_LEFT;
          frame_open <= last_byte ? !stat_q[ST_LAST] : 1'b1;
        end
        S_RETURN: begin
          if (stat_q[ST_WRAP]) begin
            use_base <= 1'b1;
          end else begin
            use_base <= 1'b0;
            cur_desc <= desc_q + STEP_DESC;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txr_bytepipe.sv
module txr_bytepipe
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [LANE_W-1:0] iss_lane,
  input  logic              iss_sof,
  input  logic              iss_eof,
  input  logic              iss_crc,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              fr_valid,
  output logic [7:0]        fr_data,
  output logic              fr_sof,
  output logic              fr_eof,
  output logic              fr_crc
);
  logic              p1_valid, p1_sof, p1_eof, p1_crc;
  logic [LANE_W-1:0] p1_lane;
  logic [7:0]        lane_b [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_b[g] = mem_rdata[8*g +: 8];
  end

  // Stage 1 waits for the RAM word; stage 2 selects the byte lane.
  always_ff @(posedge clk) begin
    if (rst) begin
      p1_valid <= 1'b0;
      p1_sof   <= 1'b0;
      p1_eof   <= 1'b0;
      p1_crc   <= 1'b0;
      p1_lane  <= '0;
      fr_valid <= 1'b0;
      fr_data  <= '0;
      fr_sof   <= 1'b0;
      fr_eof   <= 1'b0;
      fr_crc   <= 1'b0;
    end else begin
      p1_valid <= iss_valid;
      p1_sof   <= iss_sof;
      p1_eof   <= iss_eof;
      p1_crc   <= iss_crc;
      p1_lane  <= iss_lane;
      fr_valid <= p1_valid;
      fr_data  <= p1_valid ? lane_b[p1_lane] : 8'h00;
      fr_sof   <= p1_valid && p1_sof;
      fr_eof   <= p1_valid && p1_eof;
      fr_crc   <= p1_valid && p1_crc;
    end
  end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [MEM_AW-1:0] sw_addr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic [MEM_AW+1:0] ring_base,
  input  logic              halt_clr,
  input  logic              gstop_req,
  output logic              gstop_ack,
  output logic              tx_halted,
  output logic              tx_irq,
  output logic              fr_valid,
  output logic [7:0]        fr_data,
  output logic              fr_sof,
  output logic              fr_eof,
  output logic              fr_crc
);
  logic [MEM_AW-1:0] e_addr;
  logic              e_we;
  logic [WORD_W-1:0] e_wdata, e_rdata;
  logic              iss_valid, iss_sof, iss_eof, iss_crc;
  logic [LANE_W-1:0] iss_lane;

  txr_dpram #(.AW(MEM_AW), .DW(WORD_W)) u_ram (
    .clk     (clk),
    .a_we    (sw_we),
    .a_addr  (sw_addr),
    .a_wdata (sw_wdata),
    .a_rdata (sw_rdata),
    .b_we    (e_we),
    .b_addr  (e_addr),
    .b_wdata (e_wdata),
    .b_rdata (e_rdata)
  );

  txr_ctrl #(.AW(MEM_AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ring_base (ring_base),
    .halt_clr  (halt_clr),
    .gstop_req (gstop_req),
    .mem_rdata (e_rdata),
    .mem_addr  (e_addr),
    .mem_we    (e_we),
    .mem_wdata (e_wdata),
    .iss_valid (iss_valid),
    .iss_lane  (iss_lane),
    .iss_sof   (iss_sof),
    .iss_eof   (iss_eof),
    .iss_crc   (iss_crc),
    .tx_halted (tx_halted),
    .gstop_ack (gstop_ack),
    .tx_irq    (tx_irq)
  );

  txr_bytepipe u_pipe (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_lane  (iss_lane),
    .iss_sof   (iss_sof),
    .iss_eof   (iss_eof),
    .iss_crc   (iss_crc),
    .mem_rdata (e_rdata),
    .fr_valid  (fr_valid),
    .fr_data   (fr_data),
    .fr_sof    (fr_sof),
    .fr_eof    (fr_eof),
    .fr_crc    (fr_crc)
  );
endmodule

// File: rtl/txr_checker.sv
module txr_checker (
  input logic clk,
  input logic rst,
  input logic fr_valid,
  input logic fr_sof,
  input logic fr_eof,
  input logic fr_crc,
  input logic tx_halted,
  input logic halt_clr,
  input logic gstop_req,
  input logic gstop_ack,
  input logic tx_irq
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (rst)           open_q <= 1'b0;
    else if (fr_valid) open_q <= !fr_eof;
  end

  AST_SOF_OPENS: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && !open_q) |-> fr_sof); // R8
  AST_SOF_ONCE: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && open_q) |-> !fr_sof); // R8
  AST_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
    (fr_sof || fr_eof) |-> fr_valid); // R8
  AST_CRC_WITH_EOF: assert property (@(posedge clk) disable iff (rst)
    fr_crc |-> fr_eof); // R9
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_halted && !halt_clr) |=> tx_halted); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    tx_halted |-> !fr_valid); // R7
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (gstop_ack && gstop_req) |=> gstop_ack); // R11
  AST_STOP_CLOSED: assert property (@(posedge clk) disable iff (rst)
    gstop_ack |-> (!open_q && !fr_valid)); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq); // R10
endmodule

bind txring_engine txr_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .fr_valid  (fr_valid),
  .fr_sof    (fr_sof),
  .fr_eof    (fr_eof),
  .fr_crc    (fr_crc),
  .tx_halted (tx_halted),
  .halt_clr  (halt_clr),
  .gstop_req (gstop_req),
  .gstop_ack (gstop_ack),
  .tx_irq    (tx_irq)
);

// File: tb/sim_txring_engine.sv
`timescale 1ns/1ps
module sim_txring_engine;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sw_we = 1'b0;
  logic [AW-1:0] sw_addr = '0;
  logic [31:0]   sw_wdata = '0;
  logic [31:0]   sw_rdata;
  logic [AW+1:0] ring_base = '0;
  logic          halt_clr = 1'b0;
  logic          gstop_req = 1'b0;
  logic          gstop_ack, tx_halted, tx_irq;
  logic          fr_valid, fr_sof, fr_eof, fr_crc;
  logic [7:0]    fr_data;

  always #10 clk = ~clk;

  txring_engine #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .ring_base(ring_base), .halt_clr(halt_clr),
    .gstop_req(gstop_req), .gstop_ack(gstop_ack), .tx_halted(tx_halted),
    .tx_irq(tx_irq), .fr_valid(fr_valid), .fr_data(fr_data), .fr_sof(fr_sof),
    .fr_eof(fr_eof), .fr_crc(fr_crc)
  );

  localparam logic [15:0] F_RDY  = 16'h8000;
  localparam logic [15:0] F_WRAP = 16'h2000;
  localparam logic [15:0] F_INTR = 16'h1000;
  localparam logic [15:0] F_LAST = 16'h0800;
  localparam logic [15:0] F_CRC  = 16'h0400;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic [7:0] sh [1024];
  logic [7:0] cap_d [512];
  logic       cap_s [512];
  logic       cap_e [512];
  logic       cap_c [512];
  int         cap_n = 0, irq_n = 0;
  logic [7:0] ex_d [64];
  logic       ex_s [64];
  logic       ex_e [64];
  logic       ex_c [64];

  always @(negedge clk) begin
    if (fr_valid && cap_n < 512) begin
      cap_d[cap_n] = fr_data;
      cap_s[cap_n] = fr_sof;
      cap_e[cap_n] = fr_eof;
      cap_c[cap_n] = fr_crc;
      cap_n = cap_n + 1;
    end
    if (tx_irq) irq_n = irq_n + 1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish (got %0d cycles, expected < 150000)", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int waddr, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = waddr[AW-1:0]; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic rd(input int waddr, output logic [31:0] d);
    @(negedge clk);
    sw_addr = waddr[AW-1:0];
    @(negedge clk);
    d = sw_rdata;
  endtask

  task automatic put_buf(input int addr, input int len, input int seed);
    for (int i = 0; i < len; i++) sh[addr+i] = 8'(seed + i * 19);
    for (int w = addr / 4; w <= (addr + len - 1) / 4; w++)
      wr(w, {sh[4*w+3], sh[4*w+2], sh[4*w+1], sh[4*w]});
  endtask

  task automatic put_desc(input int ba, input logic [15:0] st, input int len, input int ptr);
    wr(ba / 4, {st, 16'(len)});
    wr(ba / 4 + 1, 32'(ptr));
  endtask

  task automatic pulse_clr();
    @(negedge clk); halt_clr = 1'b1;
    @(negedge clk); halt_clr = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!tx_halted && n < 3000) begin @(negedge clk); n++; end
    chk(tx_halted, req, "engine reached halt", tx_halted, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify_run(input string req, input int b, input int n);
    int bad_d = 0, bad_s = 0, bad_e = 0, bad_c = 0;
    int fa = 0, fe = 0;
    chk(cap_n - b == n, "R4", {req, " byte count"}, cap_n - b, n);
    for (int i = 0; i < n; i++) begin
      if (cap_d[b+i] !== ex_d[i]) begin
        if (bad_d == 0) begin fa = cap_d[b+i]; fe = ex_d[i]; end
        bad_d++;
      end
      if (cap_s[b+i] !== ex_s[i]) bad_s++;
      if (cap_e[b+i] !== ex_e[i]) bad_e++;
      if (cap_c[b+i] !== ex_c[i]) bad_c++;
    end
    chk(bad_d == 0, "R4", {req, " byte data"}, fa, fe);
    chk(bad_s == 0, "R8", {req, " start marker mismatches"}, bad_s, 0);
    chk(bad_e == 0, "R8", {req, " end marker mismatches"}, bad_e, 0);
    chk(bad_c == 0, "R9", {req, " crc flag mismatches"}, bad_c, 0);
  endtask

  initial begin
    logic [31:0] rv;
    int b, ib;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(tx_halted == 1'b1, "R1", "halted after reset", tx_halted, 1);
    chk(fr_valid == 1'b0, "R1", "no frame after reset", fr_valid, 0);
    chk(gstop_ack == 1'b0 && tx_irq == 1'b0, "R1", "ack/irq low after reset",
        {gstop_ack, tx_irq}, 0);

    // R12: software port read-back
    for (int k = 0; k < 4; k++) begin
      wr(200 + k, 32'hA5000000 + 32'(k * 4097));
      rd(200 + k, rv);
      chk(rv == 32'hA5000000 + 32'(k * 4097), "R12", "software read-back",
          rv, 32'hA5000000 + 32'(k * 4097));
    end

    // R2 R3 R6: two-slot ring at base 0, swept over length and offset
    ring_base = '0;
    put_desc(0, 16'h0, 1, 0);
    put_desc(8, 16'h0, 1, 0);
    begin
      int slot = 0;
      for (int len = 1; len <= 9; len++) begin
        for (int off = 0; off < 4; off++) begin
          logic [15:0] st;
          st = F_RDY | F_LAST | F_INTR | (off[0] ? F_CRC : 16'h0) | (slot == 1 ? F_WRAP : 16'h0);
          put_buf(256 + off, len, len * 37 + off * 11);
          put_desc(slot * 8, st, len, 256 + off);
          for (int i = 0; i < len; i++) begin
            ex_d[i] = sh[256 + off + i];
            ex_s[i] = (i == 0);
            ex_e[i] = (i == len - 1);
            ex_c[i] = (i == len - 1) && off[0];
          end
          b = cap_n; ib = irq_n;
          pulse_clr();
          wait_halt("R6");
          verify_run("R6 sweep", b, len);
          chk(irq_n - ib == 1, "R10", "one irq per descriptor", irq_n - ib, 1);
          rd(slot * 2, rv);
          chk(rv == {st & 16'h7FFF, 16'(len)}, "R5", "writeback word", rv,
              {st & 16'h7FFF, 16'(len)});
          slot = 1 - slot;
        end
      end
    end

    // R8: one frame over three descriptors, new base
    rst = 1'b1; ring_base = 10'h040;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    put_buf(384, 3, 7);
    put_buf(417, 2, 90);
    put_buf(451, 4, 200);
    put_desc(64, F_RDY, 3, 384);
    put_desc(72, F_RDY | F_INTR, 2, 417);
    put_desc(80, F_RDY | F_INTR | F_LAST | F_WRAP | F_CRC, 4, 451);
    for (int i = 0; i < 9; i++) begin
      ex_d[i] = (i < 3) ? sh[384 + i] : (i < 5) ? sh[417 + i - 3] : sh[451 + i - 5];
      ex_s[i] = (i == 0);
      ex_e[i] = (i == 8);
      ex_c[i] = (i == 8);
    end
    b = cap_n; ib = irq_n;
    pulse_clr();
    wait_halt("R6");
    verify_run("R8 chained", b, 9);
    chk(irq_n - ib == 2, "R10", "irq only for INTR descriptors", irq_n - ib, 2);
    rd(16, rv); chk(rv == 32'h00000003, "R5", "writeback d0", rv, 32'h00000003);
    rd(18, rv); chk(rv == 32'h10000002, "R5", "writeback d1", rv, 32'h10000002);
    rd(20, rv); chk(rv == 32'h3C000004, "R5", "writeback d2", rv, 32'h3C000004);

    // R7: halted engine ignores a newly ready descriptor until halt_clr
    put_desc(64, F_RDY | F_LAST, 1, 384);
    b = cap_n;
    repeat (30) @(negedge clk);
    chk(cap_n == b, "R7", "no bytes while halted", cap_n - b, 0);
    chk(tx_halted == 1'b1, "R7", "still halted", tx_halted, 1);
    rd(16, rv); chk(rv == 32'h88000001, "R7", "descriptor untouched while halted", rv, 32'h88000001);
    ex_d[0] = sh[384]; ex_s[0] = 1; ex_e[0] = 1; ex_c[0] = 0;
    pulse_clr();
    wait_halt("R7");
    verify_run("R7 refetch", b, 1);
    rd(16, rv); chk(rv == 32'h08000001, "R5", "writeback after refetch", rv, 32'h08000001);

    // R11: graceful stop raised inside a two-descriptor frame
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    put_buf(512, 6, 33);
    put_buf(530, 2, 150);
    put_buf(544, 1, 77);
    put_desc(64, F_RDY, 6, 512);
    put_desc(72, F_RDY | F_LAST | F_WRAP | F_CRC, 2, 530);
    for (int i = 0; i < 8; i++) begin
      ex_d[i] = (i < 6) ? sh[512 + i] : sh[530 + i - 6];
      ex_s[i] = (i == 0); ex_e[i] = (i == 7); ex_c[i] = (i == 7);
    end
    b = cap_n;
    pulse_clr();
    begin
      int n = 0;
      while (!fr_valid && n < 200) begin @(negedge clk); n++; end
    end
    gstop_req = 1'b1;
    begin
      int n = 0;
      while (!gstop_ack && n < 2000) begin @(negedge clk); n++; end
    end
    repeat (2) @(negedge clk);
    chk(gstop_ack == 1'b1, "R11", "stop acknowledged", gstop_ack, 1);
    chk(tx_halted == 1'b0, "R11", "stopped, not halted", tx_halted, 0);
    verify_run("R11 frame finished", b, 8);
    put_desc(64, F_RDY | F_LAST, 1, 544);
    repeat (30) @(negedge clk);
    chk(cap_n - b == 8, "R11", "no fetch while stopped", cap_n - b, 8);
    chk(gstop_ack == 1'b1, "R11", "ack held", gstop_ack, 1);
    rd(16, rv); chk(rv[31] == 1'b1, "R11", "descriptor still owned by software side", rv[31], 1);
    gstop_req = 1'b0;
    wait_halt("R11");
    chk(gstop_ack == 1'b0, "R11", "ack released", gstop_ack, 0);
    ex_d[0] = sh[544]; ex_s[0] = 1; ex_e[0] = 1; ex_c[0] = 0;
    verify_run("R11 resumed", b + 8, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule